// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block holds a small set of recently used page mappings so that a virtual page number can be turned into a physical page number without a trip to the in-memory page tables. A requester presents a virtual page number, a page offset and an access type, and holds them steady. Every stored entry is compared with the page number at once. On a usable hit, the physical address, the read-only flag and the cache-disable flag appear in the same cycle.

A lookup can fail in three ways. The page may be absent. The access may write a page that is marked read-only, which gives a protection fault. Or the access may write a writable page whose cached dirty flag is still clear, so the in-memory dirty flag has to be updated. For an absent page or a clean-page write, the block asks an external walker for the entry and holds that request until the walker answers. It then stores the answer and the held lookup completes on the next cycle. A flush input empties the whole buffer in one cycle.

The slot that receives a refilled entry is chosen in this order. First, a slot that already holds the same page number. Otherwise, the lowest-numbered empty slot. Otherwise, the slot named by a rotating pointer.

Top module: `xlat_cache`

## Requirements
- R1: After synchronous reset, no entry is valid. A lookup misses, and `walk_req`, `hit` and `fault` are 0.
- R2: A read lookup that matches a valid entry sets `hit` in the same cycle. `pa` is then the cached physical page number in the upper bits and the unchanged `req_off` in the lower `OFF_W` bits, and `ro` and `nc` show the cached flags.
- R3: A write lookup that matches a valid entry whose read-only flag is 1 sets `fault` and leaves `hit` at 0. It never starts a walk.
- R4: A write lookup that matches a writable entry whose dirty flag is 0 does not hit. It starts a walk, and the refill overwrites that same slot, so no other entry is lost.
- R5: A lookup that neither hits nor faults, made while no walk is pending, raises `walk_req` on the next cycle with `walk_vpn` set to the requested page. When `walk_ack` arrives, the returned entry is installed and `walk_req` falls on the next cycle, and the held lookup then hits.
- R6: When no slot holds the page, a refill goes to the lowest-numbered invalid slot. When all slots are valid, it goes to the slot named by a rotating pointer. The pointer starts at slot 0 and advances by one, wrapping, after each such eviction.
- R7: A `flush` pulse invalidates every entry by the next cycle.
- R8: If `flush` and `walk_ack` arrive in the same cycle, the flush wins and the returned entry is not installed.
- R9: While a walk is pending, `walk_req` stays 1 and `walk_vpn` stays unchanged until `walk_ack` arrives.
- R10: A read that matches an entry whose dirty flag is 0 is an ordinary hit. The dirty flag only matters for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present, held until done |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_vpn | input | VPN_W | Virtual page number to translate |
| req_off | input | OFF_W | Page offset, passed through to `pa` |
| flush | input | 1 | Invalidate all entries |
| hit | output | 1 | Translation valid this cycle |
| fault | output | 1 | Write to a read-only cached page |
| pa | output | PPN_W+OFF_W | Physical address {ppn, offset} |
| ro | output | 1 | Read-only flag of the hit entry |
| nc | output | 1 | Cache-disable flag of the hit entry |
| walk_req | output | 1 | Walk request to the external walker |
| walk_vpn | output | VPN_W | Page number being walked |
| walk_ack | input | 1 | Walker answer valid (one-cycle pulse) |
| walk_ppn | input | PPN_W | Returned physical page number |
| walk_ro | input | 1 | Returned read-only flag |
| walk_dirty | input | 1 | Returned dirty flag |
| walk_nc | input | 1 | Returned cache-disable flag |

## Verification
The bench first fills all eight slots from a table of mappings, each with a distinct physical page and its own flag mix. This shows that the comparison picks the right slot and that the offset is passed through unchanged. Writes are then made to a read-only page and to a clean writable page. Reads are made to a clean page. These patterns separate a fault, a forced refill and a plain hit. A run of misses against a full buffer shows the rotating-pointer eviction. A refill against a slot that already holds the page shows that the slot is reused and no other entry is evicted. Flushes issued alone and together with a walker answer show that invalidation takes priority.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  // cached permission and state flags of one mapping
  typedef struct packed {
    logic ro;     // write not allowed
    logic dirty;  // page already marked written in memory
    logic nc;     // do not cache data of this page
  } perm_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } state_t;
endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int N_ENT = 8,
  parameter int TAG_W = 4
) (
  input  logic [N_ENT-1:0]            valid,
  input  logic [N_ENT-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]            key,
  output logic [N_ENT-1:0]            match
);
  // one comparator per slot, all working in parallel
  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    assign match[g] = valid[g] && (tags[g] == key);
  end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int N_ENT = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_ENT-1:0] valid,
  input  logic [N_ENT-1:0] same,
  input  logic             fill,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] rr_q;
  logic             evict;

  always_comb begin
    idx = rr_q;
    // descending scan so the lowest invalid slot wins
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (!valid[i]) idx = IDX_W'(i);
    end
    // a slot already holding the page overrides everything
    for (int i = 0; i < N_ENT; i++) begin
      if (same[i]) idx = IDX_W'(i);
    end
  end

  assign evict = !(|same) && (&valid);

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q <= '0;
    end else if (fill && evict) begin
      if (rr_q == IDX_W'(N_ENT - 1)) rr_q <= '0;
      else                           rr_q <= rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int N_ENT = 8,
  parameter int VPN_W = 4,
  parameter int PPN_W = 3,
  parameter int OFF_W = 12,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1,
  localparam int PA_W  = PPN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic [OFF_W-1:0] req_off,
  input  logic             flush,
  output logic             hit,
  output logic             fault,
  output logic [PA_W-1:0]  pa,
  output logic             ro,
  output logic             nc,
  output logic             walk_req,
  output logic [VPN_W-1:0] walk_vpn,
  input  logic             walk_ack,
  input  logic [PPN_W-1:0] walk_ppn,
  input  logic             walk_ro,
  input  logic             walk_dirty,
  input  logic             walk_nc
);
  import xlat_pkg::*;

  // entry storage: kept in flops because every tag is read each cycle
  logic [N_ENT-1:0]            valid_q;
  logic [N_ENT-1:0][VPN_W-1:0] tag_q;
  logic [N_ENT-1:0][PPN_W-1:0] ppn_q;
  perm_t [N_ENT-1:0]           perm_q;

  state_t           state_q;
  logic [VPN_W-1:0] wvpn_q;

  logic [N_ENT-1:0] look_match;
  logic [N_ENT-1:0] walk_match;
  logic [IDX_W-1:0] vic_idx;
  logic             any_match;
  logic [PPN_W-1:0] sel_ppn;
  perm_t            sel_perm;
  logic             need_walk;
  logic             install;

  xlat_match #(.N_ENT(N_ENT), .TAG_W(VPN_W)) u_look (
    .valid(valid_q), .tags(tag_q), .key(req_vpn), .match(look_match)
  );

  // second comparator bank keyed on the page being walked, for slot reuse
  xlat_match #(.N_ENT(N_ENT), .TAG_W(VPN_W)) u_wmatch (
    .valid(valid_q), .tags(tag_q), .key(wvpn_q), .match(walk_match)
  );

  assign install = (state_q == ST_WALK) && walk_ack && !flush;

  xlat_victim #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_vic (
    .clk(clk), .rst(rst), .valid(valid_q), .same(walk_match),
    .fill(install), .idx(vic_idx)
  );

  // one-hot OR mux of the matching entry
  always_comb begin
    sel_ppn  = '0;
    sel_perm = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (look_match[i]) begin
        sel_ppn  = sel_ppn | ppn_q[i];
        sel_perm = sel_perm | perm_q[i];
      end
    end
  end

  assign any_match = |look_match;

  always_comb begin
    hit   = 1'b0;
    fault = 1'b0;
    if (req_valid && any_match) begin
      if (req_write && sel_perm.ro)          fault = 1'b1;
      else if (!req_write || sel_perm.dirty) hit   = 1'b1;
    end
  end

  assign need_walk = req_valid && !hit && !fault;
  assign pa        = {sel_ppn, req_off};
  assign ro        = sel_perm.ro;
  assign nc        = sel_perm.nc;
  assign walk_req  = (state_q == ST_WALK);
  assign walk_vpn  = wvpn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      wvpn_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (need_walk && !flush) begin
          state_q <= ST_WALK;
          wvpn_q  <= req_vpn;
        end
        ST_WALK: if (walk_ack) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      valid_q <= '0;
    end else if (install) begin
      valid_q[vic_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (install) begin
      tag_q[vic_idx]  <= wvpn_q;
      ppn_q[vic_idx]  <= walk_ppn;
      perm_q[vic_idx] <= '{ro: walk_ro, dirty: walk_dirty, nc: walk_nc};
    end
  end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int VPN_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             flush,
  input logic             hit,
  input logic             fault,
  input logic             walk_req,
  input logic [VPN_W-1:0] walk_vpn,
  input logic             walk_ack
);
  // R1: reset leaves no walk pending
  a_r1_reset_idle: assert property (@(posedge clk) rst |=> !walk_req);

  // R3: a protection fault seen while idle never starts a walk
  a_r3_fault_no_walk: assert property (@(posedge clk) disable iff (rst)
    (fault && !walk_req) |=> !walk_req);

  // R2 / R3: hit and fault are exclusive
  a_r2_hit_fault_excl: assert property (@(posedge clk) disable iff (rst)
    !(hit && fault));

  // R5: an unserved lookup while idle raises the walk request
  a_r5_miss_requests: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !hit && !fault && !walk_req && !flush) |=> walk_req);

  // R5: an answered walk ends
  a_r5_walk_ends: assert property (@(posedge clk) disable iff (rst)
    (walk_req && walk_ack) |=> !walk_req);

  // R9: pending walk is held steady
  a_r9_walk_held: assert property (@(posedge clk) disable iff (rst)
    (walk_req && !walk_ack) |=> (walk_req && $stable(walk_vpn)));

  // R7: nothing hits the cycle after a flush
  a_r7_flush_empty: assert property (@(posedge clk) disable iff (rst)
    flush |=> !hit);
endmodule

bind xlat_cache xlat_cache_chk #(.VPN_W(VPN_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .flush(flush),
  .hit(hit), .fault(fault), .walk_req(walk_req), .walk_vpn(walk_vpn),
  .walk_ack(walk_ack)
);

// File: tb/sim_xlat_cache.sv
`timescale 1ns/100ps
module sim_xlat_cache;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [3:0]  req_vpn = '0;
  logic [11:0] req_off = '0;
  logic        flush = 1'b0;
  logic        hit, fault, ro, nc, walk_req;
  logic [14:0] pa;
  logic [3:0]  walk_vpn;
  logic        walk_ack = 1'b0;
  logic [2:0]  walk_ppn = '0;
  logic        walk_ro = 1'b0, walk_dirty = 1'b0, walk_nc = 1'b0;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  xlat_cache u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_vpn(req_vpn), .req_off(req_off), .flush(flush),
    .hit(hit), .fault(fault), .pa(pa), .ro(ro), .nc(nc),
    .walk_req(walk_req), .walk_vpn(walk_vpn), .walk_ack(walk_ack),
    .walk_ppn(walk_ppn), .walk_ro(walk_ro), .walk_dirty(walk_dirty),
    .walk_nc(walk_nc)
  );

  // fill table: {vpn[3:0], ppn[2:0], ro, dirty, nc}
  localparam logic [9:0] FILL [8] = '{
    {4'd0, 3'd3, 1'b0, 1'b1, 1'b0},
    {4'd1, 3'd4, 1'b0, 1'b0, 1'b0},
    {4'd2, 3'd5, 1'b1, 1'b1, 1'b0},
    {4'd3, 3'd6, 1'b0, 1'b0, 1'b0},
    {4'd4, 3'd7, 1'b0, 1'b1, 1'b0},
    {4'd5, 3'd0, 1'b0, 1'b0, 1'b1},
    {4'd6, 3'd1, 1'b0, 1'b1, 1'b0},
    {4'd7, 3'd2, 1'b0, 1'b0, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive a lookup at a falling edge and keep it held
  task automatic put(input logic w, input logic [3:0] vpn, input logic [11:0] off);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_vpn = vpn; req_off = off;
  endtask

  // look without letting the FSM see the request at a rising edge
  task automatic probe(input logic w, input logic [3:0] vpn, input string tag,
                       input logic exp_hit);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_vpn = vpn; req_off = 12'h0;
    #1 check(tag, {31'b0, hit}, {31'b0, exp_hit});
    #0.5 req_valid = 1'b0;
  endtask

  // answer a pending walk with a one-cycle acknowledgement
  task automatic answer(input logic [2:0] p, input logic r, input logic d,
                        input logic c, input logic with_flush);
    @(negedge clk);
    walk_ack = 1'b1; walk_ppn = p; walk_ro = r; walk_dirty = d; walk_nc = c;
    flush = with_flush;
    @(negedge clk);
    walk_ack = 1'b0; flush = 1'b0;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1: empty after reset
    check("R1 walk_req", {31'b0, walk_req}, 32'd0);
    check("R1 fault", {31'b0, fault}, 32'd0);
    probe(1'b0, 4'd3, "R1 miss after reset", 1'b0);

    // R5/R2/R6: fill all slots from the table
    for (int i = 0; i < 8; i++) begin
      put(1'b0, FILL[i][9:6], 12'(i * 273 + 5));
      @(negedge clk);
      check("R5 walk_req raised", {31'b0, walk_req}, 32'd1);
      check("R5 walk_vpn", {28'b0, walk_vpn}, {28'b0, FILL[i][9:6]});
      walk_ack = 1'b1; walk_ppn = FILL[i][5:3];
      walk_ro = FILL[i][2]; walk_dirty = FILL[i][1]; walk_nc = FILL[i][0];
      @(negedge clk);
      walk_ack = 1'b0;
      check("R5 walk_req dropped", {31'b0, walk_req}, 32'd0);
      check("R2 hit", {31'b0, hit}, 32'd1);
      check("R2 pa", {17'b0, pa}, {17'b0, FILL[i][5:3], 12'(i * 273 + 5)});
      check("R2 ro", {31'b0, ro}, {31'b0, FILL[i][2]});
      check("R2 nc", {31'b0, nc}, {31'b0, FILL[i][0]});
      req_valid = 1'b0;
    end

    // R10: read of clean page hits
    probe(1'b0, 4'd1, "R10 read clean hit", 1'b1);
    probe(1'b0, 4'd3, "R10 read clean hit", 1'b1);

    // R3: write to read-only page faults, no walk
    put(1'b1, 4'd2, 12'h0);
    #1 check("R3 fault", {31'b0, fault}, 32'd1);
    check("R3 no hit", {31'b0, hit}, 32'd0);
    @(negedge clk);
    check("R3 no walk", {31'b0, walk_req}, 32'd0);
    req_valid = 1'b0;

    // R4: write to clean writable page forces walk, same slot reused
    put(1'b1, 4'd1, 12'h0);
    #1 check("R4 no hit", {31'b0, hit}, 32'd0);
    check("R4 no fault", {31'b0, fault}, 32'd0);
    @(negedge clk);
    check("R4 walk_req", {31'b0, walk_req}, 32'd1);
    walk_ack = 1'b1; walk_ppn = 3'd4; walk_ro = 1'b0; walk_dirty = 1'b1; walk_nc = 1'b0;
    @(negedge clk);
    walk_ack = 1'b0;
    check("R4 write hit after refill", {31'b0, hit}, 32'd1);
    req_valid = 1'b0;
    probe(1'b0, 4'd0, "R4 slot reuse keeps vpn0", 1'b1);

    // R9/R6: full buffer, hold walk, then rotating eviction
    put(1'b0, 4'd8, 12'h0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R9 walk held", {31'b0, walk_req}, 32'd1);
      check("R9 walk_vpn held", {28'b0, walk_vpn}, 32'd8);
    end
    req_valid = 1'b0;
    answer(3'd1, 1'b0, 1'b1, 1'b0, 1'b0);
    probe(1'b0, 4'd8, "R6 new entry hits", 1'b1);
    probe(1'b0, 4'd0, "R6 slot0 evicted first", 1'b0);
    probe(1'b0, 4'd1, "R6 slot1 kept", 1'b1);
    put(1'b0, 4'd9, 12'h0);
    @(negedge clk);
    req_valid = 1'b0;
    answer(3'd2, 1'b0, 1'b1, 1'b0, 1'b0);
    probe(1'b0, 4'd1, "R6 slot1 evicted second", 1'b0);
    probe(1'b0, 4'd2, "R6 slot2 kept", 1'b1);

    // R8: flush together with walker answer drops the install
    put(1'b0, 4'd10, 12'h0);
    @(negedge clk);
    check("R8 walk_req", {31'b0, walk_req}, 32'd1);
    req_valid = 1'b0;
    answer(3'd6, 1'b0, 1'b1, 1'b0, 1'b1);
    probe(1'b0, 4'd10, "R8 dropped install", 1'b0);
    probe(1'b0, 4'd8, "R8 flush cleared", 1'b0);

    // R7: flush alone clears a fresh entry; R6 lowest invalid used after flush
    put(1'b0, 4'd4, 12'h0);
    @(negedge clk);
    req_valid = 1'b0;
    answer(3'd7, 1'b0, 1'b1, 1'b0, 1'b0);
    probe(1'b0, 4'd4, "R7 entry present", 1'b1);
    @(negedge clk) flush = 1'b1;
    @(negedge clk) flush = 1'b0;
    probe(1'b0, 4'd4, "R7 flushed", 1'b0);
    check("R7 no walk after flush", {31'b0, walk_req}, 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule